// File: doc/BRIEF.md
# Tagged Conversion Result FIFO

This block buffers conversion results on their way from an analog-to-digital converter to software. Each accepted result is stored with two side fields: a tag that records what started the conversion, and the number of the channel that was converted. Results leave in arrival order through a read port. The read port always shows the oldest entry, and a pop strobe removes it.

The block counts accepted writes and raises an interrupt request flag when that count reaches N+1. N comes from a small stage-count input. For a one-shot scan over several channels, N is set to one less than the number of channels, so the flag rises when the last channel lands. The request reaches the interrupt output only while the enable input is high. Every read word carries an invalid bit, so software can tell when it has read an empty FIFO.

A chip uses two instances. The scan instance has 16 entries and a 4-bit stage-count field. The priority instance has 4 entries and a 2-bit stage-count field.

Top module: `tagged_result_fifo`

## Requirements
- R1: After reset, `emptyFlag`=1, `fullFlag`=0, `irqFlag`=0, `irqOut`=0 and `overrunFlag`=0.
- R2: A write strobe accepted by the FIFO stores the result, tag and channel. Entries leave in write order. The read word is laid out as result in bits [11:0], invalid in bit 12, tag in bits [14:13] and channel in bits [19:15].
- R3: The first accepted write clears `emptyFlag`. Popping the last entry sets `emptyFlag` again.
- R4: Bit 12 of `rdWord` is 1 whenever the FIFO is empty, and all other bits are 0 in that case. Bit 12 is 0 whenever a valid entry is shown.
- R5: A pop while the FIFO is empty changes nothing: the FIFO stays empty and a later write is read back as the first entry.
- R6: `irqFlag` becomes 1 on the clock edge of the accepted write that makes the count of writes since the last clear equal to `stageCount`+1.
- R7: `irqFlag` stays at 1 until an `irqClear` strobe. The clear restarts the write count. A write in the same cycle as a clear counts as the first write of the new run.
- R8: `irqOut` is 1 exactly when `irqFlag` and `irqEnable` are both 1.
- R9: A write while the FIFO holds DEPTH entries is dropped, even if a pop happens in the same cycle. The stored contents stay unchanged, and `overrunFlag` is set and stays set until reset.
- R10: `fullFlag` is 1 exactly when DEPTH entries are held.
- R11: A write and a pop in the same cycle, on a FIFO that is neither empty nor full, both take effect. The entry count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Write strobe for one conversion result |
| wrResult | input | DATA_W | Conversion result |
| wrTag | input | TAG_W | Start-factor tag |
| wrChan | input | CH_W | Channel number |
| popReq | input | 1 | Removes the head entry |
| rdWord | output | DATA_W+1+TAG_W+CH_W | Head entry, with the invalid bit at position DATA_W |
| emptyFlag | output | 1 | No entries held |
| fullFlag | output | 1 | DEPTH entries held |
| stageCount | input | CNT_W | N: interrupt after N+1 writes |
| irqEnable | input | 1 | Gates the interrupt output |
| irqClear | input | 1 | Clears the request flag and restarts the count |
| irqFlag | output | 1 | Interrupt request flag |
| irqOut | output | 1 | Gated interrupt to the CPU |
| overrunFlag | output | 1 | Sticky: a write was dropped because the FIFO was full |

## Verification
The bench builds the priority-sized configuration: DEPTH=4 and CNT_W=2. At that size every stage-count value from 0 to 3 can be swept in full, and each sweep fills the FIFO to capacity and drains it. Full, overrun and wrap-around of both pointers are reached within a few writes. The default 16-entry build shares the same generate paths, so the same behaviour covers the scan instance.

// File: rtl/trf_pkg.sv
package trf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } fifo_strobe_t;
endpackage

// File: rtl/trf_ctrl.sv
module trf_ctrl #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int RUN_W = CNT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrValid,
  input  logic                  popReq,
  input  logic [CNT_W-1:0]      stageCount,
  input  logic                  irqEnable,
  input  logic                  irqClear,
  output trf_pkg::fifo_strobe_t strobes,
  output logic [PTR_W-1:0]      wrPtr,
  output logic [PTR_W-1:0]      rdPtr,
  output logic                  emptyFlag,
  output logic                  fullFlag,
  output logic                  irqFlag,
  output logic                  irqOut,
  output logic                  overrunFlag
);
  localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [OCC_W-1:0] occupancy;
  logic [RUN_W-1:0] runCount;
  logic [RUN_W-1:0] runTarget;
  logic [RUN_W-1:0] runBase;
  logic [RUN_W-1:0] runNext;
  logic             push, pop;

  assign emptyFlag = (occupancy == '0);
  assign fullFlag  = (occupancy == OCC_FULL);
  assign push      = wrValid && !fullFlag;
  assign pop       = popReq && !emptyFlag;
  assign strobes   = '{push: push, pop: pop};
  assign irqOut    = irqFlag && irqEnable;

  assign runTarget = {1'b0, stageCount} + RUN_W'(1);
  assign runBase   = irqClear ? '0 : runCount;

  always_comb begin
    runNext = runBase;
    if (push && runBase < runTarget) runNext = runBase + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occupancy   <= '0;
      wrPtr       <= '0;
      rdPtr       <= '0;
      overrunFlag <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      case ({push, pop})
        2'b10:   occupancy <= occupancy + OCC_W'(1);
        2'b01:   occupancy <= occupancy - OCC_W'(1);
        default: occupancy <= occupancy;
      endcase
      if (wrValid && fullFlag) overrunFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runCount <= '0;
      irqFlag  <= 1'b0;
    end else begin
      runCount <= runNext;
      if (push && runBase < runTarget && runNext == runTarget)
        irqFlag <= 1'b1;
      else if (irqClear)
        irqFlag <= 1'b0;
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_FULL);

  assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && fullFlag && !popReq) |=> (fullFlag && overrunFlag));

  assert_empty_pop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (popReq && emptyFlag && !wrValid) |=> (emptyFlag && $stable(rdPtr)));

  assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqFlag) |-> $past(wrValid));

  assert_write_clears_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrValid && !popReq) |=> !emptyFlag);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overrunFlag |=> overrunFlag);
endmodule

// File: rtl/trf_datapath.sv
module trf_datapath #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  parameter int TAG_W  = 2,
  parameter int CH_W   = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = DATA_W + TAG_W + CH_W,
  localparam int OUT_W = ENT_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  trf_pkg::fifo_strobe_t strobes,
  input  logic [PTR_W-1:0]      wrPtr,
  input  logic [PTR_W-1:0]      rdPtr,
  input  logic                  emptyFlag,
  input  logic [DATA_W-1:0]     wrResult,
  input  logic [TAG_W-1:0]      wrTag,
  input  logic [CH_W-1:0]       wrChan,
  output logic [OUT_W-1:0]      rdWord
);
  logic [ENT_W-1:0] entries [DEPTH];
  logic [ENT_W-1:0] inEntry;
  logic [ENT_W-1:0] headEntry;

  assign inEntry = {wrChan, wrTag, wrResult};

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entries[e] <= '0;
      else if (strobes.push && wrPtr == PTR_W'(e)) entries[e] <= inEntry;
    end
  end

  assign headEntry = entries[rdPtr];

  always_comb begin
    if (emptyFlag)
      rdWord = {{(CH_W + TAG_W){1'b0}}, 1'b1, {DATA_W{1'b0}}};
    else
      rdWord = {headEntry[ENT_W-1:DATA_W], 1'b0, headEntry[DATA_W-1:0]};
  end

  assert_invalid_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    emptyFlag |-> (rdWord[DATA_W] == 1'b1));
endmodule

// File: rtl/tagged_result_fifo.sv
module tagged_result_fifo #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 4,
  parameter int DATA_W = 12,
  parameter int TAG_W  = 2,
  parameter int CH_W   = 5,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OUT_W = DATA_W + 1 + TAG_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrResult,
  input  logic [TAG_W-1:0]  wrTag,
  input  logic [CH_W-1:0]   wrChan,
  input  logic              popReq,
  output logic [OUT_W-1:0]  rdWord,
  output logic              emptyFlag,
  output logic              fullFlag,
  input  logic [CNT_W-1:0]  stageCount,
  input  logic              irqEnable,
  input  logic              irqClear,
  output logic              irqFlag,
  output logic              irqOut,
  output logic              overrunFlag
);
  trf_pkg::fifo_strobe_t strobes;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  trf_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .popReq(popReq),
    .stageCount(stageCount), .irqEnable(irqEnable), .irqClear(irqClear),
    .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .irqFlag(irqFlag),
    .irqOut(irqOut), .overrunFlag(overrunFlag)
  );

  trf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .CH_W(CH_W)) u_data (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .emptyFlag(emptyFlag), .wrResult(wrResult), .wrTag(wrTag), .wrChan(wrChan),
    .rdWord(rdWord)
  );

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irqOut |-> irqEnable) and (irqOut |-> irqFlag));
endmodule

// File: tb/tb_tagged_result_fifo.sv
module tb_tagged_result_fifo;
  localparam int DEPTH = 4;
  localparam int CNT_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrValid = 1'b0;
  logic [11:0] wrResult = '0;
  logic [1:0]  wrTag = '0;
  logic [4:0]  wrChan = '0;
  logic popReq = 1'b0;
  logic [19:0] rdWord;
  logic emptyFlag, fullFlag, irqFlag, irqOut, overrunFlag;
  logic [CNT_W-1:0] stageCount = '0;
  logic irqEnable = 1'b0;
  logic irqClear = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  tagged_result_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrResult(wrResult),
    .wrTag(wrTag), .wrChan(wrChan), .popReq(popReq), .rdWord(rdWord),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .stageCount(stageCount),
    .irqEnable(irqEnable), .irqClear(irqClear), .irqFlag(irqFlag),
    .irqOut(irqOut), .overrunFlag(overrunFlag)
  );

  function automatic logic [19:0] expWord(int k);
    logic [11:0] r = 12'((k * 37 + 5) & 12'hfff);
    logic [1:0]  t = 2'(k % 4);
    logic [4:0]  c = 5'((k * 3) % 32);
    return {c, t, 1'b0, r};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle with optional write of pattern k, pop and clear; sampled at next negedge
  task automatic cycle(bit doWr, int k, bit doPop, bit doClr);
    logic [19:0] w = expWord(k);
    wrValid  = doWr;
    wrResult = w[11:0];
    wrTag    = w[14:13];
    wrChan   = w[19:15];
    popReq   = doPop;
    irqClear = doClr;
    @(negedge clk);
    wrValid = 1'b0; popReq = 1'b0; irqClear = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seq = 0;
    repeat (2) @(negedge clk);
    check("R1 empty", 32'(emptyFlag), 1);
    check("R1 full", 32'(fullFlag), 0);
    check("R1 irq", 32'({irqFlag, irqOut}), 0);
    check("R1 overrun", 32'(overrunFlag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 empty word", 32'(rdWord), 32'h1000);

    // R5: pop on empty has no effect
    cycle(0, 0, 1, 0);
    check("R5 still empty", 32'(emptyFlag), 1);
    cycle(1, 99, 0, 0);
    check("R5 R3 first write", 32'(rdWord), 32'(expWord(99)));
    check("R3 empty cleared", 32'(emptyFlag), 0);
    cycle(0, 0, 1, 1);
    check("R3 empty after drain", 32'(emptyFlag), 1);

    // sweep every stage count; fill to full, drain
    for (int n = 0; n < DEPTH; n++) begin
      stageCount = CNT_W'(n);
      cycle(0, 0, 0, 1);
      for (int w = 1; w <= DEPTH; w++) begin
        cycle(1, seq + w, 0, 0);
        check("R6 irq flag", 32'(irqFlag), 32'(w >= n + 1));
        irqEnable = (w % 2) == 0;
        #1;
        check("R8 irq out", 32'(irqOut), 32'((w >= n + 1) && (w % 2 == 0)));
        check("R10 full", 32'(fullFlag), 32'(w == DEPTH));
      end
      for (int w = 1; w <= DEPTH; w++) begin
        check("R2 head", 32'(rdWord), 32'(expWord(seq + w)));
        cycle(0, 0, 1, 0);
      end
      check("R7 flag held", 32'(irqFlag), 1);
      check("R4 empty after drain", 32'(rdWord), 32'h1000);
      seq += DEPTH;
    end

    // R7: clear together with a write, N=0: that write starts new run and sets flag
    stageCount = '0;
    cycle(1, 200, 0, 1);
    check("R7 clear+write N0", 32'(irqFlag), 1);
    stageCount = 2'd1;
    cycle(1, 201, 0, 1);
    check("R7 clear+write N1", 32'(irqFlag), 0);
    cycle(1, 202, 0, 0);
    check("R7 second write N1", 32'(irqFlag), 1);

    // R11: simultaneous push/pop on 3 entries
    cycle(1, 203, 1, 0);
    check("R11 head after push+pop", 32'(rdWord), 32'(expWord(201)));
    check("R11 not full", 32'(fullFlag), 0);
    cycle(1, 204, 0, 0);
    check("R10 full again", 32'(fullFlag), 1);

    // R9: overrun, including with concurrent pop
    check("R9 no overrun yet", 32'(overrunFlag), 0);
    cycle(1, 300, 0, 0);
    check("R9 overrun set", 32'(overrunFlag), 1);
    cycle(1, 301, 1, 0);
    check("R9 dropped with pop", 32'(fullFlag), 0);
    for (int k = 202; k <= 204; k++) begin
      check("R9 contents kept", 32'(rdWord), 32'(expWord(k)));
      cycle(0, 0, 1, 0);
    end
    check("R9 R3 empty", 32'(emptyFlag), 1);
    check("R9 sticky", 32'(overrunFlag), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule